// File: doc/BRIEF.md
# Alternating Two-Channel Byte Interleaver

This block joins two byte streams into one. Each stream is read from its own half of a line buffer. The block reads through one shared byte-wide read port, so it moves one byte per cycle. Two channels of equal rank share that port, and an arbiter grants them turn and turn about. A channel has its own enable, base address, byte count and cell size. When a display line is stored with all odd-position pixels first and all even-position pixels after them, channel 0 walks the first half and channel 1 walks the second half. The joined output then gives back the pixels in display order.

A single cell trigger paces the work. Each trigger gives every channel that still has bytes one cell of work. Within that cell the two channels take alternate bytes until both cells are empty. The block then waits for the next trigger. Each granted read produces one output byte one cycle later, tagged with the channel it came from. A done level reports that every enabled channel has moved its full count.

The controller is a four-state machine:
- `S_IDLE` is the state after reset.
- `S_WAIT` waits for a trigger.
- `S_MOVE` transfers the bytes of the current cells.
- `S_DONE` means the line is complete.

The transitions are:
- **load**: `S_IDLE` or `S_DONE` to `S_WAIT`, on start when at least one channel has work.
- **empty**: `S_IDLE` or `S_DONE` to `S_DONE`, on start when no channel has work.
- **arm**: `S_WAIT` to `S_MOVE`, on the trigger.
- **cell end**: `S_MOVE` to `S_WAIT`, when the last byte of the cells moves and bytes remain.
- **line end**: `S_MOVE` to `S_DONE`, when the last byte of the line moves.

Top module: `byte_pair_interleaver`

## Requirements
- R1: After reset, `out_valid` and `done` are 0, and no output appears until a start is given.
- R2: A start is taken only in the idle or done state, and it samples the configuration of both channels. A channel whose enable is 0 or whose length is 0 moves no bytes. If neither channel has work, `done` reads 1 in the cycle after the start edge.
- R3: Each `cell_trig` seen while waiting arms, for every channel with bytes left, a cell of min(cell size, bytes left) bytes. A cell size of 0 counts as 1. Without a trigger no byte is moved.
- R4: A `cell_trig` that arrives while the cells are being moved has no effect. It neither adds bytes nor arms a later cell.
- R5: When both channels have cell bytes pending, grants alternate byte by byte. After each start, channel 0 is granted first, whatever the two base addresses are.
- R6: A channel's read address starts at its base and steps by exactly +1 per byte moved. Every granted read gives one output byte one cycle later, with `out_data` equal to the byte read and `out_chan` equal to the channel number (0 or 1).
- R7: When one channel's cell or line runs out, the other channel is served in the following cycles with no idle cycle.
- R8: `done` rises in the same cycle as the last output byte of the line. It stays 1, with no further output, until the next start.
- R9: For a line of L bytes stored odd positions first (channel 0 length ceil(L/2), channel 1 length floor(L/2), channel 1 base right after channel 0's data), the output stream equals the original line, for any cell size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load configuration and begin a line |
| ch0_en | input | 1 | Channel 0 enable |
| ch0_base | input | AW | Channel 0 first read address |
| ch0_len | input | LW | Channel 0 byte count |
| ch0_cell | input | CW | Channel 0 bytes per cell |
| ch1_en | input | 1 | Channel 1 enable |
| ch1_base | input | AW | Channel 1 first read address |
| ch1_len | input | LW | Channel 1 byte count |
| ch1_cell | input | CW | Channel 1 bytes per cell |
| cell_trig | input | 1 | Cell pacing trigger |
| rd_addr | output | AW | Read address of the granted channel |
| rd_data | input | DW | Byte at `rd_addr`, same cycle |
| out_valid | output | 1 | Output byte present |
| out_chan | output | 1 | Channel of the output byte |
| out_data | output | DW | Output byte |
| done | output | 1 | Line complete |

## Verification
Two events can fall in the same cycle. The first is the move of the final byte, which ends the cell, ends the line and raises `done`. The second is a `cell_trig` pulse that arrives while a cell is still moving. The bench provokes the first by holding the trigger high through whole lines whose lengths and cell sizes leave uneven final cells. It checks that `done` is low for every output byte except the last. It provokes the second by pulsing the trigger two cycles into a cell. It then checks that the byte count stops exactly at the armed cell size, and that only a later trigger resumes the transfer.

// File: rtl/bpi_pkg.sv
package bpi_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_MOVE,
        S_DONE
    } bpi_state_e;
endpackage

// File: rtl/bpi_channel.sv
module bpi_channel #(
    parameter int AW = 8,
    parameter int LW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic          arm,
    input  logic [CW-1:0] cell_size,
    input  logic          take,
    output logic [AW-1:0] addr,
    output logic          pend_cell,
    output logic          last_cell,
    output logic          pend_line,
    output logic          last_line
);
    logic [AW-1:0] ptr;
    logic [LW-1:0] rem;
    logic [LW-1:0] cell_left;
    logic [LW-1:0] eff_cell;

    // a cell size of zero is served as one byte
    always_comb begin
        eff_cell = LW'(cell_size);
        if (cell_size == '0) eff_cell = LW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            rem       <= '0;
            cell_left <= '0;
        end else if (load) begin
            ptr       <= base;
            rem       <= en ? len : '0;
            cell_left <= '0;
        end else begin
            if (arm) cell_left <= (rem < eff_cell) ? rem : eff_cell;
            if (take) begin
                ptr       <= ptr + AW'(1);
                rem       <= rem - LW'(1);
                cell_left <= cell_left - LW'(1);
            end
        end
    end

    assign addr      = ptr;
    assign pend_cell = (cell_left != '0);
    assign last_cell = (cell_left == LW'(1));
    assign pend_line = (rem != '0);
    assign last_line = (rem == LW'(1));
endmodule

// File: rtl/bpi_arbiter.sv
module bpi_arbiter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] req,
    output logic [1:0] gnt
);
    // last_one = 1 means channel 1 was served last, so channel 0 goes next
    logic last_one;

    always_comb begin
        gnt = 2'b00;
        if (req[0] && (!req[1] || last_one)) gnt = 2'b01;
        else if (req[1])                     gnt = 2'b10;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       last_one <= 1'b1;
        else if (clear)   last_one <= 1'b1;
        else if (|gnt)    last_one <= gnt[1];
    end
endmodule

// File: rtl/byte_pair_interleaver.sv
module byte_pair_interleaver
    import bpi_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8,
    parameter int LW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ch0_en,
    input  logic [AW-1:0] ch0_base,
    input  logic [LW-1:0] ch0_len,
    input  logic [CW-1:0] ch0_cell,
    input  logic          ch1_en,
    input  logic [AW-1:0] ch1_base,
    input  logic [LW-1:0] ch1_len,
    input  logic [CW-1:0] ch1_cell,
    input  logic          cell_trig,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          out_valid,
    output logic          out_chan,
    output logic [DW-1:0] out_data,
    output logic          done
);
    localparam int NCH = 2;

    bpi_state_e st, st_nx;

    logic          en_a   [NCH];
    logic [AW-1:0] base_a [NCH];
    logic [LW-1:0] len_a  [NCH];
    logic [CW-1:0] cell_a [NCH];
    logic [AW-1:0] addr_a [NCH];

    logic [NCH-1:0] pend_cell, last_cell, pend_line, last_line, gnt, req;
    logic load, arm, has_work, cell_end, line_end;

    assign en_a[0]   = ch0_en;
    assign en_a[1]   = ch1_en;
    assign base_a[0] = ch0_base;
    assign base_a[1] = ch1_base;
    assign len_a[0]  = ch0_len;
    assign len_a[1]  = ch1_len;
    assign cell_a[0] = ch0_cell;
    assign cell_a[1] = ch1_cell;

    assign load     = start && (st == S_IDLE || st == S_DONE);
    assign arm      = (st == S_WAIT) && cell_trig;
    assign has_work = (ch0_en && ch0_len != '0) || (ch1_en && ch1_len != '0);
    assign req      = (st == S_MOVE) ? pend_cell : '0;
    assign cell_end = &(~pend_cell | (gnt & last_cell));
    assign line_end = &(~pend_line | (gnt & last_line));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bpi_channel #(.AW(AW), .LW(LW), .CW(CW)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .en        (en_a[c]),
            .base      (base_a[c]),
            .len       (len_a[c]),
            .arm       (arm),
            .cell_size (cell_a[c]),
            .take      (gnt[c]),
            .addr      (addr_a[c]),
            .pend_cell (pend_cell[c]),
            .last_cell (last_cell[c]),
            .pend_line (pend_line[c]),
            .last_line (last_line[c])
        );
    end

    bpi_arbiter i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .req   (req),
        .gnt   (gnt)
    );

    assign rd_addr = gnt[1] ? addr_a[1] : addr_a[0];

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE, S_DONE: if (start) st_nx = has_work ? S_WAIT : S_DONE;
            S_WAIT:         if (cell_trig) st_nx = S_MOVE;
            S_MOVE:         if (cell_end) st_nx = line_end ? S_DONE : S_WAIT;
            default:        st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= |gnt;
            out_chan  <= gnt[1];
            out_data  <= rd_data;
        end
    end

    assign done = (st == S_DONE);
endmodule

// File: rtl/bpi_checker.sv
module bpi_checker
    import bpi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       out_valid,
    input logic       done,
    input logic [1:0] gnt,
    input logic [1:0] req
);
    assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_alt_after_0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[0] |=> (req != 2'b11) || gnt[1]);

    assert_alt_after_1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[1] |=> (req != 2'b11) || gnt[0]);

    assert_grant_gives_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> out_valid);

    assert_no_byte_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> !out_valid);

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !out_valid);
endmodule

bind byte_pair_interleaver bpi_checker i_bpi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_valid (out_valid),
    .done      (done),
    .gnt       (gnt),
    .req       (req)
);

// File: tb/test_byte_pair_interleaver.sv
module test_byte_pair_interleaver;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ch0_en = 1'b0, ch1_en = 1'b0;
    logic [7:0] ch0_base = '0, ch1_base = '0, ch0_len = '0, ch1_len = '0;
    logic [3:0] ch0_cell = '0, ch1_cell = '0;
    logic       cell_trig = 1'b0;
    logic [7:0] rd_addr, rd_data, out_data;
    logic       out_valid, out_chan, done;

    logic [7:0] mem [256];
    logic [7:0] line [$];
    logic [7:0] got_d [$];
    logic       got_c [$];
    logic       got_dn [$];
    int         got_t [$];
    int         cyc = 0;
    int         total = 0;
    int         bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign rd_data = mem[rd_addr];

    byte_pair_interleaver i_byte_pair_interleaver (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ch0_en(ch0_en), .ch0_base(ch0_base), .ch0_len(ch0_len), .ch0_cell(ch0_cell),
        .ch1_en(ch1_en), .ch1_base(ch1_base), .ch1_len(ch1_len), .ch1_cell(ch1_cell),
        .cell_trig(cell_trig), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data), .done(done)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            got_d.push_back(out_data);
            got_c.push_back(out_chan);
            got_dn.push_back(done);
            got_t.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input bit e0, input int b0, input int l0, input int c0,
                            input bit e1, input int b1, input int l1, input int c1);
        got_d.delete(); got_c.delete(); got_dn.delete(); got_t.delete();
        @(negedge clk);
        ch0_en = e0; ch0_base = 8'(b0); ch0_len = 8'(l0); ch0_cell = 4'(c0);
        ch1_en = e1; ch1_base = 8'(b1); ch1_len = 8'(l1); ch1_cell = 4'(c1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        cell_trig = 1'b1;
        @(negedge clk);
        cell_trig = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        rst_n = 1'b1;
        idle(4);
        check(got_d.size() == 0, "R1 no output before start", got_d.size(), 0);
    endtask

    task automatic t_empty();
        do_start(1'b0, 0, 9, 1, 1'b1, 20, 0, 1);
        check(done == 1'b1, "R2 empty start sets done next cycle", int'(done), 1);
        idle(3);
        check(got_d.size() == 0, "R2 empty start moves nothing", got_d.size(), 0);
    endtask

    // random line, odd positions first then even positions, rebuilt by the merge
    task automatic t_line(input int len, input int csz);
        int h0, h1, base, mism, chbad, early_done;
        h0 = (len + 1) / 2;
        h1 = len / 2;
        base = 8 + int'($urandom_range(0, 100));
        line.delete();
        for (int i = 0; i < len; i++) line.push_back(8'($urandom));
        for (int i = 0; i < h0; i++) mem[base + i] = line[2*i];
        for (int i = 0; i < h1; i++) mem[base + h0 + i] = line[2*i + 1];
        do_start(1'b1, base, h0, csz, 1'b1, base + h0, h1, csz);
        cell_trig = 1'b1;
        for (int k = 0; k < 1000 && !done; k++) @(negedge clk);
        cell_trig = 1'b0;
        idle(2);
        check(got_d.size() == len, "R9 merged length", got_d.size(), len);
        mism = 0; chbad = 0; early_done = 0;
        for (int i = 0; i < got_d.size() && i < len; i++) begin
            if (got_d[i] != line[i]) mism++;
            if (got_c[i] != ((i < 2*h1) ? 1'(i % 2) : 1'b0)) chbad++;
            if (got_dn[i] && i != len - 1) early_done++;
        end
        check(mism == 0, "R9 R6 merged bytes equal original line", mism, 0);
        check(chbad == 0, "R5 R6 channel tags alternate", chbad, 0);
        check(early_done == 0, "R8 done only with the last byte", early_done, 0);
        check(got_dn.size() > 0 && got_dn[got_dn.size()-1] == 1'b1,
              "R8 done with last byte", got_dn.size(), len);
        check(done == 1'b1, "R8 done held after line", int'(done), 1);
    endtask

    task automatic t_pacing();
        for (int i = 0; i < 16; i++) mem[60 + i] = 8'(i + 1);
        do_start(1'b1, 60, 1, 1, 1'b1, 61, 1, 1);
        idle(6);
        check(got_d.size() == 0, "R3 nothing moves without trigger", got_d.size(), 0);
        pulse_trig();
        idle(6);
        check(got_d.size() == 2, "R3 one trigger moves one cell per channel", got_d.size(), 2);
        // cells of four, second trigger lands mid-cell
        do_start(1'b1, 60, 8, 4, 1'b1, 68, 8, 4);
        pulse_trig();
        pulse_trig();
        idle(15);
        check(got_d.size() == 8, "R4 mid-cell trigger ignored", got_d.size(), 8);
        check(done == 1'b0, "R4 line not finished after one cell", int'(done), 0);
        pulse_trig();
        idle(12);
        check(got_d.size() == 16 && done == 1'b1, "R3 next trigger finishes line", got_d.size(), 16);
    endtask

    task automatic t_first();
        mem[200] = 8'hA5; mem[201] = 8'hA6;
        mem[5] = 8'h5A; mem[6] = 8'h5B;
        do_start(1'b1, 200, 2, 1, 1'b1, 5, 2, 1);
        pulse_trig();
        idle(4);
        check(got_c.size() == 2 && got_c[0] == 1'b0, "R5 channel 0 granted first",
              (got_c.size() > 0) ? int'(got_c[0]) : -1, 0);
        check(got_d.size() == 2 && got_d[0] == 8'hA5 && got_d[1] == 8'h5A,
              "R6 first bytes from each base", (got_d.size() > 0) ? int'(got_d[0]) : -1, 'hA5);
        pulse_trig();
        idle(4);
        check(got_d.size() == 4 && got_d[2] == 8'hA6 && got_d[3] == 8'h5B,
              "R6 address steps by one", (got_d.size() > 2) ? int'(got_d[2]) : -1, 'hA6);
    endtask

    task automatic t_early();
        logic exp_c [6] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
        int cbad;
        for (int i = 0; i < 5; i++) mem[10 + i] = 8'(8'h10 + i);
        for (int i = 0; i < 2; i++) mem[40 + i] = 8'(8'h40 + i);
        do_start(1'b1, 10, 5, 4, 1'b1, 40, 2, 4);
        pulse_trig();
        idle(10);
        check(got_d.size() == 6, "R7 first cell byte count", got_d.size(), 6);
        cbad = 0;
        for (int i = 0; i < 6 && i < got_c.size(); i++) if (got_c[i] != exp_c[i]) cbad++;
        check(cbad == 0, "R7 channel order 0,1,0,1,0,0", cbad, 0);
        check(got_t.size() == 6 && got_t[5] - got_t[0] == 5, "R7 no idle cycle in cell",
              (got_t.size() == 6) ? got_t[5] - got_t[0] : -1, 5);
        pulse_trig();
        idle(5);
        check(got_d.size() == 7 && got_d[6] == 8'h14 && done == 1'b1,
              "R7 R8 remaining byte then done", (got_d.size() == 7) ? int'(got_d[6]) : -1, 'h14);
    endtask

    task automatic t_disabled();
        int cbad;
        for (int i = 0; i < 4; i++) mem[90 + i] = 8'(8'h90 + i);
        do_start(1'b1, 90, 4, 2, 1'b0, 120, 6, 2);
        cell_trig = 1'b1;
        idle(12);
        cell_trig = 1'b0;
        cbad = 0;
        foreach (got_c[i]) if (got_c[i] != 1'b0) cbad++;
        check(got_d.size() == 4 && cbad == 0, "R2 disabled channel moves nothing", got_d.size(), 4);
        check(done == 1'b1, "R2 done with one channel disabled", int'(done), 1);
        idle(5);
        check(got_d.size() == 4, "R8 no output while done", got_d.size(), 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        foreach (mem[i]) mem[i] = 8'(i);
        t_reset();
        t_empty();
        t_pacing();
        t_first();
        t_early();
        t_disabled();
        t_line(17, 1);
        t_line(24, 3);
        t_line(31, 7);
        t_line(10, 0);
        t_line(1, 2);
        t_line(60, 15);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule